// File: doc/BRIEF.md
# Page Map with Shadow Dirty Bit

This block is a virtual-to-real page map. Each virtual page has a 16-bit entry as software sees it: a write-protect flag, a dirty flag, a referenced flag and a 12-bit real page number. Inside the block, entries are kept in a storage format with its own flag order. That storage treats write-protect plus dirty as an empty ("vacant") slot whatever the referenced flag holds. To represent write-protect, dirty and referenced all set together, the block stores the entry with dirty cleared and records the lost dirty flag in a shadow bit array. The array has one bit per real page.

A client issues one operation at a time through a valid/ready request with a 2-bit opcode. The operations are: associate (write a whole entry), set-flags (replace the flags, keep the old real page and return the old entry) and get-flags (read the entry). Each accepted request ends with a one-cycle `done` pulse. The pulse carries the result entry and a vacant indication. After reset every storage slot holds a real page number beyond the 12-bit range. A read of such a slot reports it vacant and rewrites the slot as a proper vacant slot.

Top module: `page_map_shadow`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken when `req_valid` and `req_ready` are both high. Every taken request produces exactly one `done` pulse, one cycle wide. `req_ready` returns high in the cycle after that pulse.
- R2: The opcode encoding is 0 for associate, 1 for set-flags, 2 for get-flags and 3 for no operation. Associate and no operation return entry 0 with `rsp_vacant` low. No operation leaves the map unchanged.
- R3: The software entry places write-protect in bit 14, dirty in bit 13, referenced in bit 12 and the real page in bits 11:0. Bit 15 is ignored on writes and always reads 0.
- R4: A get-flags after an associate returns the written entry, with bit 15 cleared, for all eight flag combinations. This includes referenced being set again after the write cleared it in storage.
- R5: An entry written with write-protect, dirty and referenced all set reads back as 0x7000 plus its page, with `rsp_vacant` low.
- R6: The shadow bit belongs to a real page. Any associate to the same real page, from any virtual page, that does not request all three flags clears it, so the first entry then reads dirty as 0. Shadow bits of other real pages are unaffected.
- R7: Set-flags returns the old entry. It then stores the requested flags with the old real page and ignores the page bits of the request.
- R8: Set-flags on a vacant entry returns that entry (0x6000 plus its page, `rsp_vacant` high) and writes nothing.
- R9: After reset, a get-flags or set-flags on any virtual page returns 0x6000 with `rsp_vacant` high. The entry then stays vacant.
- R10: When `rsp_vacant` is high, bits 14:12 of `rsp_entry` are 110. Vacant means write-protect and dirty set, referenced clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, able to take a request |
| req_op | input | 2 | Operation: 0 associate, 1 set-flags, 2 get-flags, 3 none |
| req_vpn | input | VPN_W (8) | Virtual page number |
| req_entry | input | 16 | Entry (associate) or new flags (set-flags), software layout |
| done | output | 1 | One-cycle completion pulse |
| rsp_entry | output | 16 | Result entry, software layout, valid with `done` |
| rsp_vacant | output | 1 | Result entry is vacant, valid with `done` |

## Verification
The bench writes all eight flag combinations and reads each back. A design that drops the shadow bit would report the all-set combination as vacant 0x6000. A design that forgets the touch after the write would lose the referenced flag.

It then clears a shadow bit through a second virtual page that maps to the same real page, and checks a neighbouring real page for collateral damage. This catches an array indexed by virtual page, or one that indexes the wrong word or bit.

Set-flags is driven through a chain of flag changes ending on a vacant entry. A design that mixes in the request's page bits, or that writes through a vacant entry, returns the wrong page or loses vacancy. The never-written entries present after reset catch a design that skips the range check on the stored page.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int SW_W       = 16;
    localparam int RPN_W      = 12;
    localparam int STORE_PG_W = RPN_W + 1;
    localparam int SH_WORD_W  = 16;

    // software layout bit positions
    localparam int B_WP    = 14;
    localparam int B_DIRTY = 13;
    localparam int B_REF   = 12;

    typedef logic [SW_W-1:0] sw_entry_t;

    // storage layout, flags counted from the MSB: ref, spare, wp, dirty
    typedef struct packed {
        logic                  ref_f;
        logic                  spare;
        logic                  wp_f;
        logic                  dirty_f;
        logic [STORE_PG_W-1:0] page;
    } store_t;

    typedef enum logic [1:0] {
        OP_ASSOC = 2'd0,
        OP_SETF  = 2'd1,
        OP_GETF  = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_EXEC,
        PH_TOUCH,
        PH_DONE
    } phase_e;

    localparam store_t STORE_RESET  = '{ref_f: 1'b0, spare: 1'b0, wp_f: 1'b0,
                                        dirty_f: 1'b0, page: '1};
    localparam store_t STORE_VACANT = '{ref_f: 1'b0, spare: 1'b0, wp_f: 1'b1,
                                        dirty_f: 1'b1, page: '0};
endpackage

// File: rtl/pm_flag_codec.sv
module pm_flag_codec
    import pm_pkg::*;
(
    input  sw_entry_t              wr_entry,
    input  logic [RPN_W-1:0]       wr_page,
    output store_t                 wr_store,
    output logic                   wr_special,
    output logic                   wr_touch,
    input  store_t                 rd_store,
    input  logic                   rd_shadow,
    output sw_entry_t              rd_entry,
    output logic                   rd_vacant,
    output logic                   rd_bad_page
);
    logic wp_w;
    logic dirty_w;
    logic ref_w;
    logic sw_unused;

    assign wp_w    = wr_entry[B_WP];
    assign dirty_w = wr_entry[B_DIRTY];
    assign ref_w   = wr_entry[B_REF];
    assign sw_unused = ^{wr_entry[SW_W-1], wr_entry[RPN_W-1:0], rd_store.spare};

    // software -> storage: the all-set combination moves dirty into the shadow
    always_comb begin
        wr_special       = wp_w & dirty_w & ref_w;
        wr_touch         = ref_w;
        wr_store         = '0;
        wr_store.wp_f    = wp_w;
        wr_store.dirty_f = dirty_w & ~wr_special;
        wr_store.ref_f   = 1'b0;
        wr_store.page    = {1'b0, wr_page};
    end

    // storage -> software
    always_comb begin
        rd_bad_page = rd_store.page > STORE_PG_W'({RPN_W{1'b1}});
        rd_entry    = '0;
        rd_vacant   = 1'b0;
        if (rd_bad_page) begin
            rd_entry[B_WP]    = 1'b1;
            rd_entry[B_DIRTY] = 1'b1;
            rd_vacant         = 1'b1;
        end else if (rd_store.wp_f && rd_store.dirty_f) begin
            rd_entry[RPN_W-1:0] = rd_store.page[RPN_W-1:0];
            rd_entry[B_WP]      = 1'b1;
            rd_entry[B_DIRTY]   = 1'b1;
            rd_vacant           = 1'b1;
        end else begin
            rd_entry[RPN_W-1:0] = rd_store.page[RPN_W-1:0];
            rd_entry[B_WP]      = rd_store.wp_f;
            rd_entry[B_DIRTY]   = rd_store.dirty_f | rd_shadow;
            rd_entry[B_REF]     = rd_store.ref_f;
        end
    end
endmodule

// File: rtl/pm_map_store.sv
module pm_map_store
    import pm_pkg::*;
#(
    parameter int VPN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [VPN_W-1:0] waddr,
    input  store_t           wdata,
    input  logic [VPN_W-1:0] raddr,
    output store_t           rdata
);
    localparam int DEPTH = 1 << VPN_W;

    store_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= STORE_RESET;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pm_shadow_bits.sv
module pm_shadow_bits #(
    parameter int PAGE_W = 12,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] rd_page,
    output logic              rd_bit,
    input  logic              we,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic              wr_val
);
    localparam int IDX_W   = $clog2(WORD_W);
    localparam int WORDS   = (1 << PAGE_W) / WORD_W;
    localparam int WADDR_W = PAGE_W - IDX_W;

    logic [WORDS-1:0][WORD_W-1:0] bits_q;
    logic [WADDR_W-1:0]           wr_word;
    logic [IDX_W-1:0]             wr_bit;
    logic [WADDR_W-1:0]           rd_word;
    logic [IDX_W-1:0]             rd_idx;

    // word index is the page shifted right, bit position is its low bits
    assign wr_word = wr_page[PAGE_W-1:IDX_W];
    assign wr_bit  = wr_page[IDX_W-1:0];
    assign rd_word = rd_page[PAGE_W-1:IDX_W];
    assign rd_idx  = rd_page[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (we) begin
            bits_q[wr_word][wr_bit] <= wr_val;
        end
    end

    assign rd_bit = bits_q[rd_word][rd_idx];
endmodule

// File: rtl/page_map_shadow.sv
module page_map_shadow
    import pm_pkg::*;
#(
    parameter int VPN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [15:0]      req_entry,
    output logic             done,
    output logic [15:0]      rsp_entry,
    output logic             rsp_vacant
);
    typedef struct packed {
        phase_e            phase;
        op_e               op;
        logic [VPN_W-1:0]  vpn;
        sw_entry_t         arg;
        sw_entry_t         result;
        logic              vac;
    } st_t;

    st_t st_q, st_d;

    store_t           rd_store;
    logic             rd_shadow;
    sw_entry_t        old_entry;
    logic             old_vac;
    logic             old_bad;
    store_t           enc_store;
    logic             enc_special;
    logic             enc_touch;
    logic [RPN_W-1:0] wr_page;

    logic             map_we;
    store_t           map_wdata;
    logic             sh_we;

    pm_map_store #(.VPN_W(VPN_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .waddr (st_q.vpn),
        .wdata (map_wdata),
        .raddr (st_q.vpn),
        .rdata (rd_store)
    );

    assign wr_page = (st_q.op == OP_SETF) ? rd_store.page[RPN_W-1:0]
                                          : st_q.arg[RPN_W-1:0];

    pm_shadow_bits #(.PAGE_W(RPN_W), .WORD_W(SH_WORD_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_page (rd_store.page[RPN_W-1:0]),
        .rd_bit  (rd_shadow),
        .we      (sh_we),
        .wr_page (wr_page),
        .wr_val  (enc_special)
    );

    pm_flag_codec u_codec (
        .wr_entry    (st_q.arg),
        .wr_page     (wr_page),
        .wr_store    (enc_store),
        .wr_special  (enc_special),
        .wr_touch    (enc_touch),
        .rd_store    (rd_store),
        .rd_shadow   (rd_shadow),
        .rd_entry    (old_entry),
        .rd_vacant   (old_vac),
        .rd_bad_page (old_bad)
    );

    always_comb begin
        st_d      = st_q;
        map_we    = 1'b0;
        map_wdata = enc_store;
        sh_we     = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.op    = op_e'(req_op);
                    st_d.vpn   = req_vpn;
                    st_d.arg   = req_entry;
                    st_d.phase = PH_EXEC;
                end
            end
            PH_EXEC: begin
                st_d.result = '0;
                st_d.vac    = 1'b0;
                st_d.phase  = PH_DONE;
                unique case (st_q.op)
                    OP_ASSOC: begin
                        map_we = 1'b1;
                        sh_we  = 1'b1;
                        if (enc_touch) st_d.phase = PH_TOUCH;
                    end
                    OP_SETF: begin
                        st_d.result = old_entry;
                        st_d.vac    = old_vac;
                        if (old_bad) begin
                            map_we    = 1'b1;
                            map_wdata = STORE_VACANT;
                        end else if (!old_vac) begin
                            map_we = 1'b1;
                            sh_we  = 1'b1;
                            if (enc_touch) st_d.phase = PH_TOUCH;
                        end
                    end
                    OP_GETF: begin
                        st_d.result = old_entry;
                        st_d.vac    = old_vac;
                        if (old_bad) begin
                            map_we    = 1'b1;
                            map_wdata = STORE_VACANT;
                        end
                    end
                    default: begin
                    end
                endcase
            end
            PH_TOUCH: begin
                // the write cleared ref; set it again on the stored entry
                map_we          = 1'b1;
                map_wdata       = rd_store;
                map_wdata.ref_f = 1'b1;
                st_d.phase      = PH_DONE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, op: OP_NONE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = (st_q.phase == PH_IDLE);
    assign done       = (st_q.phase == PH_DONE);
    assign rsp_entry  = st_q.result;
    assign rsp_vacant = st_q.vac;
endmodule

// File: rtl/pm_checker.sv
module pm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        done,
    input logic [15:0] rsp_entry,
    input logic        rsp_vacant
);
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r1_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> (req_ready && !done));

    a_r3_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rsp_entry[15]);

    a_r10_vacant_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_vacant) |-> (rsp_entry[14:12] == 3'b110));

    a_r5_all_set_not_vacant: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_entry[14:12] == 3'b111) |-> !rsp_vacant);
endmodule

bind page_map_shadow pm_checker u_pm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done       (done),
    .rsp_entry  (rsp_entry),
    .rsp_vacant (rsp_vacant)
);

// File: tb/test_page_map_shadow.sv
module test_page_map_shadow;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_vpn = 8'd0;
    logic [15:0] req_entry = 16'd0;
    logic        done;
    logic [15:0] rsp_entry;
    logic        rsp_vacant;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [15:0] got_e;
    logic        got_v;

    page_map_shadow #(.VPN_W(8)) i_page_map_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_vpn    (req_vpn),
        .req_entry  (req_entry),
        .done       (done),
        .rsp_entry  (rsp_entry),
        .rsp_vacant (rsp_vacant)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [7:0] vpn, input logic [15:0] ent);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_vpn   = vpn;
        req_entry = ent;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        got_e = rsp_entry;
        got_v = rsp_vacant;
    endtask

    task automatic t_reset;
        check("R1 ready after reset", {15'd0, req_ready}, 16'd1);
        check("R1 no done after reset", {15'd0, done}, 16'd0);
        run_op(2'd2, 8'd5, 16'h0000);
        check("R9 get after reset entry", got_e, 16'h6000);
        check("R9 get after reset vacant", {15'd0, got_v}, 16'd1);
        run_op(2'd1, 8'd6, 16'h1000);
        check("R9 setf after reset entry", got_e, 16'h6000);
        check("R10 setf after reset vacant", {15'd0, got_v}, 16'd1);
        run_op(2'd2, 8'd6, 16'h0000);
        check("R9 stays vacant", got_e, 16'h6000);
    endtask

    task automatic t_handshake;
        run_op(2'd0, 8'd1, 16'h0001);
        check("R2 associate result", got_e, 16'h0000);
        check("R2 associate vacant", {15'd0, got_v}, 16'd0);
        check("R1 ready low during done", {15'd0, req_ready}, 16'd0);
        @(negedge clk);
        check("R1 done one cycle", {15'd0, done}, 16'd0);
        check("R1 ready back", {15'd0, req_ready}, 16'd1);
    endtask

    task automatic t_roundtrip;
        for (int f = 0; f < 8; f++) begin
            logic [15:0] ent;
            ent = 16'h8000 | 16'(f << 12) | 16'(12'h200 + f);
            run_op(2'd0, 8'(16 + f), ent);
            run_op(2'd2, 8'(16 + f), 16'h0000);
            check($sformatf("R4 R3 roundtrip flags %0d", f), got_e, ent & 16'h7FFF);
            check($sformatf("R10 roundtrip vacant %0d", f), {15'd0, got_v},
                  (f == 6) ? 16'd1 : 16'd0);
        end
    endtask

    task automatic t_shadow;
        run_op(2'd0, 8'd40, 16'h7ABC);
        run_op(2'd2, 8'd40, 16'h0000);
        check("R5 all set entry", got_e, 16'h7ABC);
        check("R5 all set not vacant", {15'd0, got_v}, 16'd0);
        run_op(2'd0, 8'd41, 16'h7ABD);
        run_op(2'd0, 8'd42, 16'h0ABC);
        run_op(2'd2, 8'd40, 16'h0000);
        check("R6 shadow cleared by same real page", got_e, 16'h5ABC);
        run_op(2'd2, 8'd41, 16'h0000);
        check("R6 neighbour page kept", got_e, 16'h7ABD);
        run_op(2'd2, 8'd42, 16'h0000);
        check("R6 plain entry", got_e, 16'h0ABC);
    endtask

    task automatic t_setflags;
        run_op(2'd0, 8'd50, 16'h0123);
        run_op(2'd1, 8'd50, 16'h2FFF);
        check("R7 returns old", got_e, 16'h0123);
        run_op(2'd2, 8'd50, 16'h0000);
        check("R7 keeps old page", got_e, 16'h2123);
        run_op(2'd1, 8'd50, 16'h7000);
        check("R7 returns previous", got_e, 16'h2123);
        run_op(2'd2, 8'd50, 16'h0000);
        check("R7 R5 all set via setf", got_e, 16'h7123);
        run_op(2'd1, 8'd50, 16'h6000);
        check("R7 returns all set", got_e, 16'h7123);
        run_op(2'd1, 8'd50, 16'h1000);
        check("R8 vacant returned", got_e, 16'h6123);
        check("R8 vacant flag", {15'd0, got_v}, 16'd1);
        run_op(2'd2, 8'd50, 16'h0000);
        check("R8 no write", got_e, 16'h6123);
    endtask

    task automatic t_noop;
        run_op(2'd0, 8'd60, 16'h3456);
        run_op(2'd3, 8'd60, 16'h1555);
        check("R2 noop result", got_e, 16'h0000);
        check("R2 noop vacant", {15'd0, got_v}, 16'd0);
        run_op(2'd2, 8'd60, 16'h0000);
        check("R2 noop leaves map", got_e, 16'h3456);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_roundtrip();
        t_shadow();
        t_setflags();
        t_noop();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        finish_run();
    end
endmodule